// File: doc/BRIEF.md
# Dual Timer/Counter

This block holds two 16-bit counting channels behind a small byte-wide register bus. Each channel keeps a low and a high count byte that software preloads and reads back. A channel advances either on an internal machine-cycle tick (interval timing) or on falling edges seen on its own external event pin (event counting). Software starts and stops each channel with a run bit. A gate option also makes the channel wait for its external gate pin to be high.

One shared mode byte chooses, per channel, a 13-bit count (an 8-bit high byte above a 5-bit prescaler), a plain 16-bit count, an 8-bit count that reloads itself from the high byte, or split operation. In split operation channel 0 becomes two independent 8-bit counters. Its upper byte borrows channel 1's run bit and overflow flag. Every rollover sets the channel's overflow flag, and the flag drives an interrupt request line. The flag clears when the interrupt is acknowledged or when software rewrites it.

Top module: `dual_tmr`

## Requirements
- R1: Registers sit at bus addresses 0 (mode), 1 (control), 2 (channel 0 low), 3 (channel 0 high), 4 (channel 1 low) and 5 (channel 1 high). All of them read as 0x00 after reset, and `irq` is 0. A write is visible on `bus_rdata` right after the clock edge that takes it. Addresses 6 and 7 read as 0x00.
- R2: Mode byte bits [3:0] configure channel 0 and bits [7:4] configure channel 1. Within a nibble: bit 3 is gate enable, bit 2 is source select (1 = external pin), and bits [1:0] are the mode (00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split).
- R3: A channel advances only when its run bit is 1 and either gate enable is 0 or its `gate_pin` bit is 1. Otherwise its count holds. With gate enable 0 the gate pin has no effect.
- R4: With source select 0 the channel advances once per clock edge on which `tick` is 1. With source select 1 it ignores `tick` and advances once per 1-to-0 transition on its `ev_pin` bit, on the second rising clock edge after the pin falls. The pin must hold each level for at least two clocks.
- R5: In mode 00 only low-byte bits [4:0] count. Bits [7:5] hold their value. When bits [4:0] wrap from 31 to 0 the high byte increments. The flag sets when the count wraps from 0xFF/31 to 0.
- R6: In mode 01 the two bytes form one 16-bit count. It wraps from 0xFFFF to 0x0000 and sets the flag.
- R7: In mode 10 only the low byte counts. When it passes 0xFF it loads the high byte's value and sets the flag. The high byte is unchanged.
- R8: When channel 0 is in mode 11, its low byte is an 8-bit counter under channel 0's run, gate and source settings and sets flag 0 on wrap. Its high byte counts `tick` while run bit 1 is set and sets flag 1 on wrap.
- R9: Channel 1 in mode 11 holds its count. While channel 0 is in mode 11, channel 1 keeps counting in its own mode but its wraps set no flag.
- R10: Control register bits are 7 = flag 1, 6 = run 1, 5 = flag 0, 4 = run 0, and bits [3:0] read as 0. `irq[i]` equals flag i. A hardware wrap sets the flag and takes priority. Otherwise `irq_ack[i]` clears it. Otherwise a control write loads the written bit.
- R11: A software write to a count byte takes priority over counting for that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Internal machine-cycle count enable |
| ev_pin | input | 2 | External event input per channel |
| gate_pin | input | 2 | External gate input per channel |
| irq_ack | input | 2 | Interrupt serviced, clears the flag per channel |
| irq | output | 2 | Interrupt request, equal to the overflow flags |

## Verification
Register writes, tick-driven counts and overflow flags all take effect on the rising edge at which the write strobe or `tick` is high. The results are read on the next falling edge. An external event is counted two rising edges after its pin falls, so each event-driven scenario holds the pin level for two full cycles before sampling. Inputs change only on falling edges. Each task reads the count bytes and `irq` just before it drives the next input, so every check lands in the cycle where the result is due.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int N_CH   = 2;

  typedef enum logic [1:0] {
    MD_13B    = 2'b00,
    MD_16B    = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    cnt_mode_e mode;
  } ch_cfg_t;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0  = 3'd2;
endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic cur_q, prev_q, cur_d, prev_d;

  always_comb begin
    cur_d  = pin;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~cur_q;

  // R4
  fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int NC = N_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic [BW-1:0]         bus_wdata,
  output logic [BW-1:0]         bus_rdata,
  input  logic [NC-1:0]         set_tf,
  input  logic [NC-1:0]         irq_ack,
  input  logic [NC-1:0][BW-1:0] cnt_lo,
  input  logic [NC-1:0][BW-1:0] cnt_hi,
  output ch_cfg_t [NC-1:0]      cfg,
  output logic [NC-1:0]         tr,
  output logic [NC-1:0]         tf,
  output logic [NC-1:0]         wr_lo,
  output logic [NC-1:0]         wr_hi
);
  localparam int RUN_BASE = BW - 2*NC;

  logic [BW-1:0] mode_q, mode_d;
  logic [NC-1:0] tr_q, tr_d, tf_q, tf_d;
  logic          wr_mode, wr_ctrl;

  always_comb begin
    wr_mode = bus_wr && (bus_addr == A_MODE);
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    for (int i = 0; i < NC; i++) begin
      wr_lo[i] = bus_wr && (bus_addr == AW'(A_CNT0 + 2*i));
      wr_hi[i] = bus_wr && (bus_addr == AW'(A_CNT0 + 2*i + 1));
    end
  end

  always_comb begin
    mode_d = wr_mode ? bus_wdata : mode_q;
    for (int i = 0; i < NC; i++) begin
      tr_d[i] = wr_ctrl ? bus_wdata[RUN_BASE + 2*i] : tr_q[i];
      if (set_tf[i])
        tf_d[i] = 1'b1;
      else if (irq_ack[i])
        tf_d[i] = 1'b0;
      else if (wr_ctrl)
        tf_d[i] = bus_wdata[RUN_BASE + 2*i + 1];
      else
        tf_d[i] = tf_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tr_q   <= '0;
      tf_q   <= '0;
    end else begin
      mode_q <= mode_d;
      tr_q   <= tr_d;
      tf_q   <= tf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE)
      bus_rdata = mode_q;
    else if (bus_addr == A_CTRL) begin
      for (int i = 0; i < NC; i++) begin
        bus_rdata[RUN_BASE + 2*i]     = tr_q[i];
        bus_rdata[RUN_BASE + 2*i + 1] = tf_q[i];
      end
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (bus_addr == AW'(A_CNT0 + 2*i))     bus_rdata = cnt_lo[i];
        if (bus_addr == AW'(A_CNT0 + 2*i + 1)) bus_rdata = cnt_hi[i];
      end
    end
  end

  assign cfg = mode_q;
  assign tr  = tr_q;
  assign tf  = tf_q;

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (cfg == $past(bus_wdata)));

  for (genvar gi = 0; gi < NC; gi++) begin : g_flag_chk
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_tf[gi] |=> tf_q[gi]);
    // R10
    flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[gi] && !set_tf[gi]) |=> !tf_q[gi]);
  end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int CH = 0,
  parameter int BW = BYTE_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ch_cfg_t       cfg,
  input  logic          tr_self,
  input  logic          tr_peer,
  input  logic          tick,
  input  logic          ev_fall,
  input  logic          gate_pin,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q,
  output logic          ovf_main,
  output logic          ovf_aux
);
  localparam bit IS_HOST = (CH == 0);

  logic [BW-1:0] lo_d, hi_d;
  logic run_ok, src_pulse, inc, hi_inc;
  logic split_host, split_idle;
  logic lo_max, hi_max, pre_max;

  assign run_ok     = tr_self & (~cfg.gate | gate_pin);
  assign src_pulse  = cfg.ext_src ? ev_fall : tick;
  assign inc        = run_ok & src_pulse;
  assign split_host = IS_HOST && (cfg.mode == MD_SPLIT);
  assign split_idle = !IS_HOST && (cfg.mode == MD_SPLIT);
  assign hi_inc     = split_host & tr_peer & tick;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_aux  = 1'b0;
    lo_max   = (lo_q == '1);
    hi_max   = (hi_q == '1);
    pre_max  = (lo_q[PW-1:0] == '1);
    if (inc && !split_idle) begin
      unique case (cfg.mode)
        MD_13B: begin
          lo_d[PW-1:0] = lo_q[PW-1:0] + 1'b1;
          if (pre_max) begin
            hi_d     = hi_q + 1'b1;
            ovf_main = hi_max;
          end
        end
        MD_16B: begin
          lo_d = lo_q + 1'b1;
          if (lo_max) begin
            hi_d     = hi_q + 1'b1;
            ovf_main = hi_max;
          end
        end
        MD_RELOAD: begin
          if (lo_max) begin
            lo_d     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: begin
          lo_d     = lo_q + 1'b1;
          ovf_main = lo_max;
        end
      endcase
    end
    if (hi_inc) begin
      hi_d    = hi_q + 1'b1;
      ovf_aux = hi_max;
    end
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !hi_inc && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  // R5
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_13B && inc && lo_q[PW-1:0] == '1 && !wr_lo && !wr_hi)
      |=> (lo_q[PW-1:0] == '0 && lo_q[BW-1:PW] == $past(lo_q[BW-1:PW])
           && hi_q == $past(hi_q) + 1'b1));

  // R6
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_16B && inc && lo_q == '1 && hi_q == '1 && !wr_lo && !wr_hi)
      |=> (lo_q == '0 && hi_q == '0));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_RELOAD && inc && lo_q == '1 && !wr_lo && !wr_hi)
      |=> (lo_q == $past(hi_q) && $stable(hi_q)));

  if (IS_HOST) begin : g_host_chk
    // R8
    split_hi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_host && hi_inc && hi_q == '1 && !wr_hi) |=> (hi_q == '0));
  end else begin : g_idle_chk
    // R9
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_idle && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  end
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dtmr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic [N_CH-1:0]   ev_pin,
  input  logic [N_CH-1:0]   gate_pin,
  input  logic [N_CH-1:0]   irq_ack,
  output logic [N_CH-1:0]   irq
);
  logic [RST_STAGES-1:0]         rs_q;
  logic                          rst_int_n;
  ch_cfg_t [N_CH-1:0]            cfg;
  logic [N_CH-1:0]               tr, tf, wr_lo, wr_hi, ev_fall;
  logic [N_CH-1:0]               ovf_main, ovf_aux, set_tf;
  logic [N_CH-1:0][BYTE_W-1:0]   cnt_lo, cnt_hi;
  logic                          ch0_split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[RST_STAGES-1];

  dtmr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .set_tf   (set_tf),
    .irq_ack  (irq_ack),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .cfg      (cfg),
    .tr       (tr),
    .tf       (tf),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi)
  );

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    dtmr_edge u_edge (
      .clk  (clk),
      .rst_n(rst_int_n),
      .pin  (ev_pin[gi]),
      .fall (ev_fall[gi])
    );

    dtmr_chan #(.CH(gi)) u_chan (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cfg     (cfg[gi]),
      .tr_self (tr[gi]),
      .tr_peer (tr[(gi + 1) % N_CH]),
      .tick    (tick),
      .ev_fall (ev_fall[gi]),
      .gate_pin(gate_pin[gi]),
      .wr_lo   (wr_lo[gi]),
      .wr_hi   (wr_hi[gi]),
      .wdata   (bus_wdata),
      .lo_q    (cnt_lo[gi]),
      .hi_q    (cnt_hi[gi]),
      .ovf_main(ovf_main[gi]),
      .ovf_aux (ovf_aux[gi])
    );
  end

  assign ch0_split = (cfg[0].mode == MD_SPLIT);

  always_comb begin
    set_tf[0] = ovf_main[0];
    set_tf[1] = ch0_split ? (|ovf_aux) : ovf_main[1];
  end

  assign irq = tf;

  // R9
  split_flag_chk: assert property (@(posedge rst_int_n ? clk : 1'b0) disable iff (!rst_int_n)
    (ch0_split && ovf_main[1] && !ovf_aux[0] && !irq_ack[1] && !tf[1]
     && !(bus_wr && bus_addr == A_CTRL)) |=> !irq[1]);
endmodule

// File: tb/dual_tmr_test.sv
`timescale 1ns/1ps
module dual_tmr_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       tick;
  logic [1:0] ev_pin, gate_pin, irq_ack, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dual_tmr uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .ev_pin(ev_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) chk_reg("R1 reset readback", 3'(a), 8'h00);
    chk("R1 reset irq", {14'h0, irq}, 16'h0000);
  endtask

  task automatic t_mode16;
    wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    chk_reg("R1 write readback lo", 3'd2, 8'hFE);
    wr(3'd1, 8'h10);
    ticks(1);
    chk_reg("R6 lo before wrap", 3'd2, 8'hFF);
    chk("R6 no flag yet", {14'h0, irq}, 16'h0000);
    ticks(1);
    chk_reg("R6 lo wrapped", 3'd2, 8'h00);
    chk_reg("R6 hi wrapped", 3'd3, 8'h00);
    chk("R6 flag set", {14'h0, irq}, 16'h0001);
    chk_reg("R10 ctrl layout", 3'd1, 8'h30);
  endtask

  task automatic t_mode13;
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    wr(3'd2, 8'h1F); wr(3'd3, 8'h12);
    wr(3'd1, 8'h10);
    ticks(1);
    chk_reg("R5 prescaler carry lo", 3'd2, 8'h00);
    chk_reg("R5 prescaler carry hi", 3'd3, 8'h13);
    chk("R5 no flag on carry", {14'h0, irq}, 16'h0000);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    ticks(1);
    chk_reg("R5 lo step", 3'd2, 8'hFF);
    ticks(1);
    chk_reg("R5 upper lo bits held", 3'd2, 8'hE0);
    chk_reg("R5 hi wrapped", 3'd3, 8'h00);
    chk("R5 flag set", {14'h0, irq}, 16'h0001);
  endtask

  task automatic t_reload;
    wr(3'd1, 8'h00); wr(3'd0, 8'h02);
    wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    wr(3'd1, 8'h10);
    ticks(2);
    chk_reg("R7 reloaded lo", 3'd2, 8'h80);
    chk_reg("R7 hi kept", 3'd3, 8'h80);
    chk("R7 flag set", {14'h0, irq}, 16'h0001);
    ticks(1);
    chk_reg("R7 counts after reload", 3'd2, 8'h81);
  endtask

  task automatic t_split;
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h10);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h50);
    ticks(2);
    chk_reg("R8 split lo", 3'd2, 8'h01);
    chk_reg("R8 split hi", 3'd3, 8'h12);
    chk_reg("R9 ch1 counts lo", 3'd4, 8'h01);
    chk_reg("R9 ch1 counts hi", 3'd5, 8'h00);
    chk("R9 ch1 wrap raises no flag, R8 flag0", {14'h0, irq}, 16'h0001);
    wr(3'd1, 8'h50);
    wr(3'd3, 8'hFF);
    ticks(1);
    chk_reg("R8 split hi wrapped", 3'd3, 8'h00);
    chk("R8 split hi sets flag1", {14'h0, irq}, 16'h0002);
  endtask

  task automatic t_ch1_hold;
    wr(3'd1, 8'h00); wr(3'd0, 8'h30);
    wr(3'd4, 8'h05); wr(3'd5, 8'h07);
    wr(3'd1, 8'h40);
    ticks(3);
    chk_reg("R9 ch1 split holds lo", 3'd4, 8'h05);
    chk_reg("R9 ch1 split holds hi", 3'd5, 8'h07);
    chk("R9 no flag", {14'h0, irq}, 16'h0000);
  endtask

  task automatic t_gate;
    wr(3'd1, 8'h00); wr(3'd0, 8'h09);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate_pin = 2'b00;
    wr(3'd1, 8'h10);
    ticks(3);
    chk_reg("R3 gated off holds", 3'd2, 8'h00);
    gate_pin = 2'b01;
    ticks(3);
    chk_reg("R3 gate open counts", 3'd2, 8'h03);
    gate_pin = 2'b00;
    wr(3'd0, 8'h01);
    ticks(2);
    chk_reg("R3 gate ignored when disabled", 3'd2, 8'h05);
    wr(3'd1, 8'h00);
    ticks(3);
    chk_reg("R3 run off holds", 3'd2, 8'h05);
  endtask

  task automatic t_events;
    wr(3'd1, 8'h00); wr(3'd0, 8'h05);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    ticks(4);
    chk_reg("R4 tick ignored in event mode", 3'd2, 8'h00);
    for (int k = 0; k < 3; k++) begin
      ev_pin[0] = 1'b1;
      repeat (2) @(negedge clk);
      ev_pin[0] = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk_reg("R4 three falling edges counted", 3'd2, 8'h03);
  endtask

  task automatic t_flags;
    wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    ticks(1);
    chk("R10 flag set", {14'h0, irq}, 16'h0001);
    irq_ack = 2'b01;
    @(negedge clk);
    irq_ack = 2'b00;
    chk("R10 ack clears", {14'h0, irq}, 16'h0000);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    ticks(1);
    chk("R10 flag set again", {14'h0, irq}, 16'h0001);
    wr(3'd1, 8'h10);
    chk("R10 software write clears", {14'h0, irq}, 16'h0000);
    wr(3'd1, 8'h20);
    chk("R10 software write sets", {14'h0, irq}, 16'h0001);
  endtask

  task automatic t_wr_priority;
    wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    tick = 1'b1;
    wr(3'd2, 8'h40);
    tick = 1'b0;
    chk_reg("R11 write beats count", 3'd2, 8'h40);
    chk_reg("R11 hi untouched", 3'd3, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    tick = 1'b0; ev_pin = '0; gate_pin = '0; irq_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode16();
    t_mode13();
    t_reload();
    t_split();
    t_ch1_hold();
    t_gate();
    t_events();
    t_flags();
    t_wr_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule